// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside the execute stage of a 32-bit core that has branch delay slots. When the core raises the take strobe, the block chooses between a pending synchronous exception and an external interrupt. If it accepts one, it saves the status word, the return address and the stack register in one clock. It also writes the event code, sets the privileged status bits and produces the handler address that the fetch unit must redirect to.

Exceptions always win over interrupts. When the status block bit is set, every exception except one special code is turned into a reset, and interrupts stay blocked unless the core is asleep. The block passes the current interrupt mask level to an external priority controller. The controller answers in the same cycle, either with a vector or with "nothing eligible".

A small state machine has three states. `ST_IDLE` waits for the strobe. `ST_EXC_DONE` and `ST_IRQ_DONE` each last one cycle and signal a completed entry. The transition `accept_exc` leads from `ST_IDLE` to `ST_EXC_DONE` and `accept_irq` leads from `ST_IDLE` to `ST_IRQ_DONE`. From either done state, `finish` returns to `ST_IDLE`. A strobe that finds nothing to take leaves the machine in `ST_IDLE` through `no_event`.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception is pending and an interrupt with a valid vector is also requested, the exception is taken: `expevt_o` receives its code, and `intevt_o` keeps its previous value.
- R2: With status bit 28 (block) set, a taken exception whose code differs from 0x1E0 is recorded as code 0x000 and handled as a reset. Code 0x1E0 keeps its own code and handling.
- R3: With status bit 28 set and no exception pending, an interrupt is not taken unless `sleep_o` is high. A blocked strobe leaves all outputs unchanged and `done_o` low.
- R4: `irq_mask_o` always equals status bits 7:4. An interrupt request without a valid vector from the controller takes nothing, and a strobe with neither an exception nor an interrupt takes nothing.
- R5: On entry, `ssr_o` gets the incoming status, `sgr_o` gets R15, and `sr_o` gets the incoming status with bits 28, 29 and 30 set.
- R6: If any delay-slot flag is set at entry, `spc_o` is the PC minus 2 and `ds_clr_o` is high in the done cycle. Otherwise `spc_o` is the PC and `ds_clr_o` stays low.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15 and force bits 7:4 to 0xF in `sr_o`, and set `pc_o` to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 set `pc_o` to the vector base + 0x400. Every other non-reset exception uses vector base + 0x100. Code 0x160 adds 2 to `spc_o`, after any delay-slot rewind.
- R9: A taken interrupt writes the vector to `intevt_o` and sets `pc_o` to the vector base + 0x600, leaving `expevt_o` unchanged.
- R10: All outputs update at the clock edge that samples an accepted strobe, and `done_o` is high for exactly the following cycle. A strobe sampled while `done_o` is high is ignored.
- R11: `sleep_o` is set by `sleep_set_i` and cleared when an event is accepted. Clearing wins when both happen at the same edge.
- R12: After reset, every output register is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Strobe asking the block to evaluate and take an event |
| exc_valid_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_req_i | input | 1 | External interrupt request |
| irq_vec_valid_i | input | 1 | Controller has an eligible vector for the current mask |
| irq_vec_i | input | 12 | Interrupt vector code from the controller |
| sleep_set_i | input | 1 | Core enters sleep |
| sr_i | input | XLEN | Current status register |
| pc_i | input | XLEN | Current program counter |
| r15_i | input | XLEN | Current stack register R15 |
| vbr_i | input | XLEN | Vector base |
| ds_i | input | DS_W | Delay-slot flags |
| irq_mask_o | output | 4 | Interrupt mask level sent to the controller |
| ssr_o | output | XLEN | Saved status |
| spc_o | output | XLEN | Saved return address |
| sgr_o | output | XLEN | Saved R15 |
| sr_o | output | XLEN | Updated status register |
| expevt_o | output | 12 | Last taken exception code |
| intevt_o | output | 12 | Last taken interrupt vector |
| pc_o | output | XLEN | Handler address |
| ds_clr_o | output | 1 | Delay-slot flags must be cleared |
| done_o | output | 1 | Entry completed; pipeline flush |
| sleep_o | output | 1 | Core is sleeping |

## Verification
The bench builds the block with its defaults: a 32-bit data path and three delay-slot flags. The 32-bit width puts the fixed reset address and the block, register-bank and privilege status bits at their real positions. Three flags allow a rewind check with each flag set alone. The reset-class codes, the special code kept under the block bit, the trap advance combined with a rewind, and a strobe held across the done cycle are all reached with these values.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int CODE_W = 12;

    localparam int SR_BL_BIT = 28;
    localparam int SR_RB_BIT = 29;
    localparam int SR_MD_BIT = 30;
    localparam int SR_FD_BIT = 15;
    localparam int SR_IM_LO  = 4;
    localparam int SR_IM_W   = 4;

    localparam logic [CODE_W-1:0] CODE_RESET    = 12'h000;
    localparam logic [CODE_W-1:0] CODE_MANRESET = 12'h020;
    localparam logic [CODE_W-1:0] CODE_MULTIHIT = 12'h140;
    localparam logic [CODE_W-1:0] CODE_TLB_RD   = 12'h040;
    localparam logic [CODE_W-1:0] CODE_TLB_WR   = 12'h060;
    localparam logic [CODE_W-1:0] CODE_TRAP     = 12'h160;
    localparam logic [CODE_W-1:0] CODE_KEEP_BL  = 12'h1E0;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_EXC,
        EV_IRQ
    } ev_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXC_DONE,
        ST_IRQ_DONE
    } seq_state_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              irq_vec_valid_i,
    input  logic [CODE_W-1:0] irq_vec_i,
    input  logic              bl_i,
    input  logic              sleep_i,
    output ev_kind_e          kind_o,
    output logic [CODE_W-1:0] code_o
);
    logic irq_open;

    assign irq_open = !bl_i || sleep_i;

    always_comb begin
        kind_o = EV_NONE;
        code_o = exc_code_i;
        if (exc_valid_i) begin
            kind_o = EV_EXC;
            if (bl_i && (exc_code_i != CODE_KEEP_BL)) begin
                code_o = CODE_RESET;
            end
        end else if (irq_req_i && irq_open && irq_vec_valid_i) begin
            kind_o = EV_IRQ;
            code_o = irq_vec_i;
        end
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              DS_W     = 3,
    parameter logic [XLEN-1:0] OFF_GEN  = 'h100,
    parameter logic [XLEN-1:0] OFF_TLB  = 'h400,
    parameter logic [XLEN-1:0] OFF_IRQ  = 'h600,
    parameter logic [XLEN-1:0] RESET_PC = 'hA000_0000
) (
    input  ev_kind_e          kind_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic [DS_W-1:0]   ds_i,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   pc_o,
    output logic              ds_any_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(2);

    logic is_exc, reset_cls, tlb_cls, trap_cls;
    logic [XLEN-1:0] rewound;

    assign is_exc    = (kind_i == EV_EXC);
    assign reset_cls = is_exc && (code_i == CODE_RESET || code_i == CODE_MANRESET
                                  || code_i == CODE_MULTIHIT);
    assign tlb_cls   = is_exc && (code_i == CODE_TLB_RD || code_i == CODE_TLB_WR);
    assign trap_cls  = is_exc && (code_i == CODE_TRAP);
    assign ds_any_o  = |ds_i;
    assign rewound   = ds_any_o ? (pc_i - STEP) : pc_i;
    assign spc_o     = trap_cls ? (rewound + STEP) : rewound;

    always_comb begin
        sr_o = sr_i;
        sr_o[SR_BL_BIT] = 1'b1;
        sr_o[SR_MD_BIT] = 1'b1;
        sr_o[SR_RB_BIT] = 1'b1;
        if (reset_cls) begin
            sr_o[SR_FD_BIT] = 1'b0;
            sr_o[SR_IM_LO +: SR_IM_W] = '1;
        end
    end

    always_comb begin
        if (kind_i == EV_IRQ)  pc_o = vbr_i + OFF_IRQ;
        else if (reset_cls)    pc_o = RESET_PC;
        else if (tlb_cls)      pc_o = vbr_i + OFF_TLB;
        else                   pc_o = vbr_i + OFF_GEN;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              DS_W     = 3,
    parameter logic [XLEN-1:0] RESET_PC = 'hA000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              irq_vec_valid_i,
    input  logic [CODE_W-1:0] irq_vec_i,
    input  logic              sleep_set_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   r15_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic [DS_W-1:0]   ds_i,
    output logic [SR_IM_W-1:0] irq_mask_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   sgr_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o,
    output logic [XLEN-1:0]   pc_o,
    output logic              ds_clr_o,
    output logic              done_o,
    output logic              sleep_o
);
    seq_state_e        state_q, state_d;
    ev_kind_e          kind;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   sr_new, spc_new, pc_new;
    logic              ds_any, accept;

    assign irq_mask_o = sr_i[SR_IM_LO +: SR_IM_W];

    exc_arbiter u_arb (
        .exc_valid_i     (exc_valid_i),
        .exc_code_i      (exc_code_i),
        .irq_req_i       (irq_req_i),
        .irq_vec_valid_i (irq_vec_valid_i),
        .irq_vec_i       (irq_vec_i),
        .bl_i            (sr_i[SR_BL_BIT]),
        .sleep_i         (sleep_o),
        .kind_o          (kind),
        .code_o          (code)
    );

    exc_target #(
        .XLEN     (XLEN),
        .DS_W     (DS_W),
        .RESET_PC (RESET_PC)
    ) u_tgt (
        .kind_i   (kind),
        .code_i   (code),
        .sr_i     (sr_i),
        .pc_i     (pc_i),
        .vbr_i    (vbr_i),
        .ds_i     (ds_i),
        .sr_o     (sr_new),
        .spc_o    (spc_new),
        .pc_o     (pc_new),
        .ds_any_o (ds_any)
    );

    assign accept = take_i && (state_q == ST_IDLE) && (kind != EV_NONE);
    assign done_o = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && kind == EV_EXC)      state_d = ST_EXC_DONE;
                else if (accept)                   state_d = ST_IRQ_DONE;
                else                               state_d = ST_IDLE;
            end
            ST_EXC_DONE: state_d = ST_IDLE;
            ST_IRQ_DONE: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssr_o    <= '0;
            spc_o    <= '0;
            sgr_o    <= '0;
            sr_o     <= '0;
            expevt_o <= '0;
            intevt_o <= '0;
            pc_o     <= '0;
            ds_clr_o <= 1'b0;
            sleep_o  <= 1'b0;
        end else begin
            ds_clr_o <= 1'b0;
            if (accept) begin
                ssr_o    <= sr_i;
                spc_o    <= spc_new;
                sgr_o    <= r15_i;
                sr_o     <= sr_new;
                pc_o     <= pc_new;
                ds_clr_o <= ds_any;
                sleep_o  <= 1'b0;
                if (kind == EV_EXC) expevt_o <= code;
                else                intevt_o <= code;
            end else if (sleep_set_i) begin
                sleep_o <= 1'b1;
            end
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !sleep_o);

    // R5
    priv_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sr_o[SR_BL_BIT] && sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT]));

    // R9
    irq_keeps_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IRQ_DONE) |-> $stable(expevt_o));

    // R1
    exc_keeps_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXC_DONE) |-> $stable(intevt_o));

    // R7
    reset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXC_DONE && pc_o == RESET_PC)
            |-> (sr_o[SR_IM_LO +: SR_IM_W] == '1 && !sr_o[SR_FD_BIT]));

    // R3
    bl_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !exc_valid_i && sr_i[SR_BL_BIT] && !sleep_o && state_q == ST_IDLE)
            |=> !done_o);
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
    localparam int XLEN = 32;
    localparam int DS_W = 3;
    localparam logic [31:0] VBR = 32'h8C00_0000;
    localparam logic [31:0] R15 = 32'h0000_BEEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic take_i = 1'b0, exc_valid_i = 1'b0, irq_req_i = 1'b0, irq_vec_valid_i = 1'b0;
    logic sleep_set_i = 1'b0;
    logic [11:0] exc_code_i = '0, irq_vec_i = '0;
    logic [31:0] sr_i = '0, pc_i = '0, r15_i = R15, vbr_i = VBR;
    logic [DS_W-1:0] ds_i = '0;
    logic [3:0]  irq_mask_o;
    logic [31:0] ssr_o, spc_o, sgr_o, sr_o, pc_o;
    logic [11:0] expevt_o, intevt_o;
    logic ds_clr_o, done_o, sleep_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    exc_entry_seq #(.XLEN(XLEN), .DS_W(DS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .exc_valid_i(exc_valid_i),
        .exc_code_i(exc_code_i), .irq_req_i(irq_req_i), .irq_vec_valid_i(irq_vec_valid_i),
        .irq_vec_i(irq_vec_i), .sleep_set_i(sleep_set_i), .sr_i(sr_i), .pc_i(pc_i),
        .r15_i(r15_i), .vbr_i(vbr_i), .ds_i(ds_i), .irq_mask_o(irq_mask_o),
        .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o), .sr_o(sr_o), .expevt_o(expevt_o),
        .intevt_o(intevt_o), .pc_o(pc_o), .ds_clr_o(ds_clr_o), .done_o(done_o),
        .sleep_o(sleep_o)
    );

    typedef struct packed {
        logic        exv;
        logic [11:0] code;
        logic        irq;
        logic        vv;
        logic [11:0] vec;
        logic [31:0] sr;
        logic [31:0] pc;
        logic [2:0]  ds;
        logic        tk;
        logic [11:0] eexp;
        logic [11:0] eint;
        logic [31:0] epc;
        logic [31:0] espc;
        logic [31:0] esr;
        logic        eclr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'h040, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 32'h0000_1000, 3'b000,
          1'b1, 12'h040, 12'h000, 32'h8C00_0400, 32'h0000_1000, 32'h7000_0030, 1'b0},
        '{1'b1, 12'h060, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 32'h0000_2000, 3'b001,
          1'b1, 12'h060, 12'h000, 32'h8C00_0400, 32'h0000_1FFE, 32'h7000_0030, 1'b1},
        '{1'b1, 12'h180, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 32'h0000_3000, 3'b000,
          1'b1, 12'h180, 12'h000, 32'h8C00_0100, 32'h0000_3000, 32'h7000_0030, 1'b0},
        '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 32'h0000_4000, 3'b000,
          1'b1, 12'h160, 12'h000, 32'h8C00_0100, 32'h0000_4002, 32'h7000_0030, 1'b0},
        '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 32'h0000_5000, 3'b100,
          1'b1, 12'h160, 12'h000, 32'h8C00_0100, 32'h0000_5000, 32'h7000_0030, 1'b1},
        '{1'b1, 12'h020, 1'b0, 1'b0, 12'h000, 32'h0000_8030, 32'h0000_6000, 3'b000,
          1'b1, 12'h020, 12'h000, 32'hA000_0000, 32'h0000_6000, 32'h7000_00F0, 1'b0},
        '{1'b1, 12'h140, 1'b0, 1'b0, 12'h000, 32'h0000_8030, 32'h0000_6100, 3'b000,
          1'b1, 12'h140, 12'h000, 32'hA000_0000, 32'h0000_6100, 32'h7000_00F0, 1'b0},
        '{1'b1, 12'h0E0, 1'b0, 1'b0, 12'h000, 32'h1000_0030, 32'h0000_6200, 3'b000,
          1'b1, 12'h000, 12'h000, 32'hA000_0000, 32'h0000_6200, 32'h7000_00F0, 1'b0},
        '{1'b1, 12'h1E0, 1'b0, 1'b0, 12'h000, 32'h1000_0030, 32'h0000_6300, 3'b000,
          1'b1, 12'h1E0, 12'h000, 32'h8C00_0100, 32'h0000_6300, 32'h7000_0030, 1'b0},
        '{1'b1, 12'h0A0, 1'b1, 1'b1, 12'h320, 32'h0000_0030, 32'h0000_6400, 3'b000,
          1'b1, 12'h0A0, 12'h000, 32'h8C00_0100, 32'h0000_6400, 32'h7000_0030, 1'b0},
        '{1'b0, 12'h000, 1'b1, 1'b1, 12'h320, 32'h0000_0030, 32'h0000_7000, 3'b010,
          1'b1, 12'h0A0, 12'h320, 32'h8C00_0600, 32'h0000_6FFE, 32'h7000_0030, 1'b1},
        '{1'b0, 12'h000, 1'b1, 1'b0, 12'h3C0, 32'h0000_0050, 32'h0000_7100, 3'b000,
          1'b0, 12'h0A0, 12'h320, 32'h8C00_0600, 32'h0000_6FFE, 32'h7000_0030, 1'b0},
        '{1'b0, 12'h000, 1'b1, 1'b1, 12'h3C0, 32'h1000_0030, 32'h0000_7200, 3'b000,
          1'b0, 12'h0A0, 12'h320, 32'h8C00_0600, 32'h0000_6FFE, 32'h7000_0030, 1'b0},
        '{1'b0, 12'h000, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 32'h0000_7300, 3'b000,
          1'b0, 12'h0A0, 12'h320, 32'h8C00_0600, 32'h0000_6FFE, 32'h7000_0030, 1'b0}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1:    return "R8";
            2, 3:    return "R8";
            4:       return "R6";
            5, 6:    return "R7";
            7, 8:    return "R2";
            9:       return "R1";
            10:      return "R9";
            11:      return "R4";
            12:      return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12 reset state
        chk(done_o == 1'b0, "R12", "done", 32'(done_o), 32'd0);
        chk(pc_o == '0 && spc_o == '0 && sr_o == '0, "R12", "pc", pc_o, 32'd0);
        chk(expevt_o == '0 && intevt_o == '0, "R12", "evt", 32'(expevt_o), 32'd0);
        chk(sleep_o == 1'b0 && ds_clr_o == 1'b0, "R12", "sleep", 32'(sleep_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            exc_valid_i = TBL[i].exv;
            exc_code_i = TBL[i].code;
            irq_req_i = TBL[i].irq;
            irq_vec_valid_i = TBL[i].vv;
            irq_vec_i = TBL[i].vec;
            sr_i = TBL[i].sr;
            pc_i = TBL[i].pc;
            ds_i = TBL[i].ds;
            take_i = 1'b1;
            #1;
            // R4 mask follows status bits 7:4
            chk(irq_mask_o == TBL[i].sr[7:4], "R4", "mask", 32'(irq_mask_o), 32'(TBL[i].sr[7:4]));
            @(posedge clk);
            #1;
            take_i = 1'b0;
            chk(done_o == TBL[i].tk, "R10", "done", 32'(done_o), 32'(TBL[i].tk));
            chk(expevt_o == TBL[i].eexp, tag_of(i), "expevt", 32'(expevt_o), 32'(TBL[i].eexp));
            chk(intevt_o == TBL[i].eint, tag_of(i), "intevt", 32'(intevt_o), 32'(TBL[i].eint));
            chk(pc_o == TBL[i].epc, tag_of(i), "pc", pc_o, TBL[i].epc);
            chk(spc_o == TBL[i].espc, "R6", "spc", spc_o, TBL[i].espc);
            chk(sr_o == TBL[i].esr, "R5", "sr", sr_o, TBL[i].esr);
            chk(ds_clr_o == TBL[i].eclr, "R6", "ds_clr", 32'(ds_clr_o), 32'(TBL[i].eclr));
            if (TBL[i].tk) begin
                chk(ssr_o == TBL[i].sr, "R5", "ssr", ssr_o, TBL[i].sr);
                chk(sgr_o == R15, "R5", "sgr", sgr_o, R15);
            end
            @(posedge clk);
            #1;
        end

        // R11 sleep set
        @(negedge clk);
        exc_valid_i = 1'b0; irq_req_i = 1'b0; sleep_set_i = 1'b1;
        @(posedge clk); #1;
        sleep_set_i = 1'b0;
        chk(sleep_o == 1'b1, "R11", "sleep set", 32'(sleep_o), 32'd1);

        // R3 blocked interrupt taken while sleeping
        @(negedge clk);
        sr_i = 32'h1000_0030; pc_i = 32'h0000_9000; ds_i = '0;
        irq_req_i = 1'b1; irq_vec_valid_i = 1'b1; irq_vec_i = 12'h5A0; take_i = 1'b1;
        @(posedge clk); #1;
        take_i = 1'b0; irq_req_i = 1'b0;
        chk(done_o == 1'b1, "R3", "sleep irq done", 32'(done_o), 32'd1);
        chk(intevt_o == 12'h5A0, "R3", "sleep irq intevt", 32'(intevt_o), 32'h5A0);
        chk(pc_o == VBR + 32'h600, "R9", "irq pc", pc_o, VBR + 32'h600);
        chk(sleep_o == 1'b0, "R11", "sleep cleared", 32'(sleep_o), 32'd0);
        @(posedge clk); #1;

        // R11 clear wins over set at the same edge
        @(negedge clk);
        sr_i = 32'h0000_0030; exc_valid_i = 1'b1; exc_code_i = 12'h180;
        sleep_set_i = 1'b1; take_i = 1'b1;
        @(posedge clk); #1;
        take_i = 1'b0; sleep_set_i = 1'b0; exc_valid_i = 1'b0;
        chk(sleep_o == 1'b0, "R11", "clear priority", 32'(sleep_o), 32'd0);
        @(posedge clk); #1;

        // R10 strobe held across the done cycle
        @(negedge clk);
        exc_valid_i = 1'b1; exc_code_i = 12'h0E0; pc_i = 32'h0000_A000; take_i = 1'b1;
        @(posedge clk); #1;
        chk(done_o == 1'b1, "R10", "first take", 32'(done_o), 32'd1);
        chk(spc_o == 32'h0000_A000, "R10", "first spc", spc_o, 32'h0000_A000);
        pc_i = 32'h0000_B000;
        @(posedge clk); #1;
        take_i = 1'b0; exc_valid_i = 1'b0;
        chk(done_o == 1'b0, "R10", "second ignored", 32'(done_o), 32'd0);
        chk(spc_o == 32'h0000_A000, "R10", "spc held", spc_o, 32'h0000_A000);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule